// File: doc/BRIEF.md
# Multiplexed Burst Bus Master

This block sequences transfers on a 32-bit bus that carries addresses and data on the same wires. A core-side request names a word address, a transfer count of one to four, the width of the target port and the direction. The block runs one address cycle and then one data cycle per transfer. It drives an active-low address strobe, an active-high address latch enable and its inverse, and a four-bit partial address that steps forward on every ready acknowledgement from the target.

During the address cycle the two low bus bits carry a code for the burst length. Write beats come from a core-side stream. Each beat is taken when the previous one is acknowledged on the bus. Read beats are returned with a one-cycle valid strobe. The read return path has no back-pressure, because the bus cannot be stalled by the core. A write stream must have its next beat present whenever `wdat_ready` is high. The block also grants bus hold, in which all driven pin groups float. In halt mode it parks the bus with values that depend on the last operation.

Top module: `mbus_burst_master`

## Requirements
- R1: In the address cycle `ad_out` equals `{req_addr, req_count}` with `ad_oe` high. The count code is 2'b00 for 1 transfer, 2'b01 for 2, 2'b10 for 3 and 2'b11 for 4.
- R2: `ads_n` is low, `ale` is high and `ale_n` is low for exactly the one address cycle. In every data cycle `ads_n` is high, `ale` is low and `ale_n` is high.
- R3: A data cycle repeats while `rdy_n` is high. The burst ends after `req_count`+1 cycles in which `rdy_n` is low. `req_ready` is high only in idle, and never during an address or data cycle.
- R4: `pa_out` starts at `{req_addr[1:0], 2'b00}`. It advances modulo 16 on each non-final ready, by 1 for width code 2'b00 (8-bit), by 2 for 2'b01 (16-bit) and by 4 for 2'b10 (32-bit). It holds during wait cycles.
- R5: In write data cycles `ad_oe` is high and all 32 bits of `ad_out` carry the current beat. The first beat is taken in the address cycle and each later beat on a non-final ready; `wdat_ready` marks each take.
- R6: In read data cycles `ad_oe` is low. `rdat_valid` is high exactly in cycles where `rdy_n` is low, with `rdat_data` equal to `ad_in`.
- R7: `hold` is granted only from idle or halt. While held, `hlda` is high, `ad_oe`, `ctl_oe` and `pa_oe` are low, and no request is accepted. A hold raised during a burst waits until the burst ends.
- R8: In halt after a write, `ad_out` is `{last write beat[31:2], last count code}` with `ad_oe` high, and no request is accepted.
- R9: In halt after a read, `ad_out` is `{last byte address[31:4], pa_out[3:2] of the last data cycle, last count code}`.
- R10: After reset the block is idle: `req_ready`=1, `ads_n`=1, `ale`=0, `ale_n`=1, `hlda`=0, `ad_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Word address (byte address bits 31:2) |
| req_count | input | 2 | Transfer count minus one |
| req_width | input | 2 | Port width code: 0 = 8, 1 = 16, 2 = 32 bit |
| wdat_in | input | 32 | Next write beat |
| wdat_ready | output | 1 | Write beat taken at this edge |
| rdat_valid | output | 1 | Read beat valid |
| rdat_data | output | 32 | Read beat |
| ad_in | input | 32 | Bus value seen at the pins |
| ad_out | output | 32 | Bus value driven |
| ad_oe | output | 1 | Bus output enable |
| ale | output | 1 | Address latch enable, active high |
| ale_n | output | 1 | Inverted address latch enable |
| ads_n | output | 1 | Address strobe, active low |
| ctl_oe | output | 1 | Enable for strobe and latch pins |
| pa_out | output | 4 | Partial low-order address |
| pa_oe | output | 1 | Partial address enable |
| rdy_n | input | 1 | Target ready, active low |
| hold | input | 1 | Bus hold request |
| hlda | output | 1 | Bus hold granted |
| halt | input | 1 | Halt mode request |

## Verification
Bursts are run in every width with different start offsets. The offsets make the partial address wrap past 15 and leave its low bits fixed, which separates a wrong step size from a missing wrap. Each burst places a different number of wait cycles before each ready. This tells a counter that stalls correctly from one that advances on the clock. It also catches a burst that ends one beat early or late. Halt is entered once after a write and once after a read, so that a wrong choice of parking source shows up as a data or address mismatch. Hold is tried from idle and raised in the middle of a burst.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int AD_W    = 32;
  localparam int WA_W    = AD_W - 2;
  localparam int PA_W    = 4;
  localparam int CNT_W   = 2;
  localparam int LANE_W  = 8;
  localparam int LANES   = AD_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_HOLD, ST_HALT
  } bus_st_e;

  function automatic logic [PA_W-1:0] pa_step(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return PA_W'(1);
      2'd1:    return PA_W'(2);
      default: return PA_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [WA_W-1:0]  req_addr,
  input  logic [CNT_W-1:0] req_count,
  input  logic             rdy_n,
  input  logic             hold,
  input  logic             halt,
  output logic             req_ready,
  output logic             take,
  output logic             step,
  output bus_st_e          st_q,
  output logic             write_q,
  output logic [WA_W-1:0]  addr_q,
  output logic [CNT_W-1:0] cnt_q
);
  bus_st_e          st_d;
  logic [CNT_W-1:0] beat_q;
  logic             ack, last;

  assign req_ready = (st_q == ST_IDLE) && !hold && !halt;
  assign take      = req_valid && req_ready;
  assign ack       = (st_q == ST_DATA) && !rdy_n;
  assign last      = (beat_q == cnt_q);
  assign step      = ack && !last;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (hold)           st_d = ST_HOLD;
        else if (halt)      st_d = ST_HALT;
        else if (req_valid) st_d = ST_ADDR;
      end
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: if (ack && last) st_d = ST_IDLE;
      ST_HOLD: if (!hold) st_d = ST_IDLE;
      ST_HALT: begin
        if (hold)       st_d = ST_HOLD;
        else if (!halt) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        beat_q  <= '0;
        write_q <= req_write;
        addr_q  <= req_addr;
        cnt_q   <= req_count;
      end else if (step) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  AST_ACCEPT_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (st_q == ST_ADDR)); // R1
  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |=> (st_q == ST_DATA)); // R2
  AST_WAIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DATA) && rdy_n) |=> ((st_q == ST_DATA) && $stable(beat_q))); // R3
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (beat_q <= cnt_q)); // R3
endmodule

// File: rtl/mbus_paddr.sv
module mbus_paddr
  import mbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [1:0]      load_off,
  input  logic [1:0]      load_width,
  input  logic            step,
  output logic [PA_W-1:0] pa_q
);
  logic [1:0] width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      width_q <= 2'd2;
    end else if (load) begin
      pa_q    <= {load_off, {(PA_W-2){1'b0}}};
      width_q <= load_width;
    end else if (step) begin
      pa_q <= pa_q + pa_step(width_q);
    end
  end

  AST_PA_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (width_q == 2'd2)) |=> (pa_q[1:0] == 2'b00)); // R4
endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_st_e          st,
  input  logic             write_q,
  input  logic [WA_W-1:0]  addr_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [PA_W-1:0]  pa_q,
  input  logic             wload,
  input  logic [AD_W-1:0]  wdat_in,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic             ale,
  output logic             ale_n,
  output logic             ads_n,
  output logic             ctl_oe,
  output logic             pa_oe,
  output logic             hlda
);
  logic [AD_W-1:0] wbuf_q;
  logic [AD_W-1:0] addr_word;
  logic [AD_W-1:0] park_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wbuf_q <= '0;
    else if (wload) wbuf_q <= wdat_in;
  end

  assign addr_word = {addr_q, cnt_q};
  assign park_word = write_q ? {wbuf_q[AD_W-1:2], cnt_q}
                             : {addr_q[WA_W-1:2], pa_q[3:2], cnt_q};

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] lane_v;
    always_comb begin
      case (st)
        ST_ADDR: lane_v = addr_word[ln*LANE_W +: LANE_W];
        ST_DATA: lane_v = wbuf_q[ln*LANE_W +: LANE_W];
        default: lane_v = park_word[ln*LANE_W +: LANE_W];
      endcase
    end
    assign ad_out[ln*LANE_W +: LANE_W] = lane_v;
  end

  assign ale    = (st == ST_ADDR);
  assign ale_n  = ~ale;
  assign ads_n  = (st != ST_ADDR);
  assign hlda   = (st == ST_HOLD);
  assign ctl_oe = !hlda;
  assign pa_oe  = !hlda;
  assign ad_oe  = !hlda && !((st == ST_DATA) && !write_q);

  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && write_q) |-> ad_oe); // R5
endmodule

// File: rtl/mbus_burst_master.sv
module mbus_burst_master
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [WA_W-1:0]   req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [1:0]        req_width,
  input  logic [AD_W-1:0]   wdat_in,
  output logic              wdat_ready,
  output logic              rdat_valid,
  output logic [AD_W-1:0]   rdat_data,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              ale_n,
  output logic              ads_n,
  output logic              ctl_oe,
  output logic [PA_W-1:0]   pa_out,
  output logic              pa_oe,
  input  logic              rdy_n,
  input  logic              hold,
  output logic              hlda,
  input  logic              halt
);
  bus_st_e          st;
  logic             take, step, write_q;
  logic [WA_W-1:0]  addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PA_W-1:0]  pa_q;

  mbus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_count (req_count),
    .rdy_n     (rdy_n),
    .hold      (hold),
    .halt      (halt),
    .req_ready (req_ready),
    .take      (take),
    .step      (step),
    .st_q      (st),
    .write_q   (write_q),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q)
  );

  mbus_paddr u_paddr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .load_off   (req_addr[1:0]),
    .load_width (req_width),
    .step       (step),
    .pa_q       (pa_q)
  );

  assign wdat_ready = write_q && ((st == ST_ADDR) || step);
  assign rdat_valid = (st == ST_DATA) && !write_q && !rdy_n;
  assign rdat_data  = ad_in;
  assign pa_out     = pa_q;

  mbus_pins u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .write_q (write_q),
    .addr_q  (addr_q),
    .cnt_q   (cnt_q),
    .pa_q    (pa_q),
    .wload   (wdat_ready),
    .wdat_in (wdat_in),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .ale_n   (ale_n),
    .ads_n   (ads_n),
    .ctl_oe  (ctl_oe),
    .pa_oe   (pa_oe),
    .hlda    (hlda)
  );

  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !ctl_oe && !pa_oe && !req_ready)); // R7
  AST_READ_LANES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_valid |-> !ad_oe); // R6
  AST_PA_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && rdy_n) |=> $stable(pa_out)); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n || (st == ST_DATA)) |-> !req_ready); // R3
endmodule

// File: tb/mbus_burst_master_tb.sv
module mbus_burst_master_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [29:0] req_addr = '0;
  logic [1:0]  req_count = '0, req_width = '0;
  logic [31:0] wdat_in = '0, ad_in = '0;
  logic        rdy_n = 1'b1, hold = 1'b0, halt = 1'b0;
  logic        req_ready, wdat_ready, rdat_valid, ad_oe, ale, ale_n, ads_n;
  logic        ctl_oe, pa_oe, hlda;
  logic [31:0] rdat_data, ad_out;
  logic [3:0]  pa_out;

  int checks = 0;
  int errors = 0;
  logic [3:0] last_pa;

  always #(CLK_P/2) clk = ~clk;

  mbus_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_count(req_count),
    .req_width(req_width), .wdat_in(wdat_in), .wdat_ready(wdat_ready),
    .rdat_valid(rdat_valid), .rdat_data(rdat_data), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .ale_n(ale_n), .ads_n(ads_n),
    .ctl_oe(ctl_oe), .pa_out(pa_out), .pa_oe(pa_oe), .rdy_n(rdy_n),
    .hold(hold), .hlda(hlda), .halt(halt)
  );

  function automatic logic [31:0] wpat(input int b);
    return 32'hC0DE_1000 + 32'h0101_0111 * b;
  endfunction

  function automatic logic [31:0] rpat(input int b);
    return 32'h5A3C_0000 ^ (32'h0011_2233 * (b + 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1 && hlda == 1'b0, "R10 idle after reset", {req_ready, hlda}, 2'b10);
    chk(ads_n && !ale && ale_n, "R10 strobes after reset", {ads_n, ale, ale_n}, 3'b101);
    chk(ad_out == 32'h0, "R10 bus value after reset", ad_out, 32'h0);
  endtask

  task automatic do_burst(input bit wr, input logic [29:0] a, input logic [1:0] code,
                          input logic [1:0] w, input int seed);
    int n;
    logic [3:0] pa, inc;
    n = int'(code) + 1;
    inc = (w == 2'd0) ? 4'd1 : (w == 2'd1) ? 4'd2 : 4'd4;
    pa = {a[1:0], 2'b00};
    @(negedge clk);
    req_write = wr; req_addr = a; req_count = code; req_width = w;
    req_valid = 1'b1; wdat_in = wpat(0);
    #1;
    chk(req_ready == 1'b1, "R3 idle accepts request", req_ready, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(!ads_n && ale && !ale_n, "R2 strobes in address cycle", {ads_n, ale, ale_n}, 3'b010);
    chk(ad_oe && ad_out == {a, code}, "R1 address cycle word and count code", ad_out, {a, code});
    chk(pa_out == pa, "R4 partial address start", pa_out, pa);
    chk(!req_ready, "R3 busy in address cycle", req_ready, 0);
    if (wr) chk(wdat_ready == 1'b1, "R5 first beat taken in address cycle", wdat_ready, 1);
    @(posedge clk);
    #1 wdat_in = wpat(1);
    for (int b = 0; b < n; b++) begin
      int nw;
      nw = (b + seed) % 3;
      for (int c = 0; c <= nw; c++) begin
        bit rd;
        rd = (c == nw);
        @(negedge clk);
        rdy_n = !rd;
        ad_in = rd ? rpat(b) : 32'hDEAD_BEEF;
        #1;
        chk(ads_n && !ale && ale_n, "R2 strobes in data cycle", {ads_n, ale, ale_n}, 3'b101);
        chk(pa_out == pa, "R4 partial address in data cycle", pa_out, pa);
        chk(!req_ready, "R3 no accept during data cycle", req_ready, 0);
        if (wr) begin
          chk(ad_oe && ad_out == wpat(b), "R5 write beat on all lanes", ad_out, wpat(b));
          chk(wdat_ready == (rd && b < n - 1), "R5 write beat take", wdat_ready, (rd && b < n - 1));
        end else begin
          chk(!ad_oe, "R6 bus released on read", ad_oe, 0);
          chk(rdat_valid == rd, "R6 read valid on ready", rdat_valid, rd);
          if (rd) chk(rdat_data == rpat(b), "R6 read data", rdat_data, rpat(b));
        end
        @(posedge clk);
      end
      #1 wdat_in = wpat(b + 2);
      last_pa = pa;
      if (b < n - 1) pa = pa + inc;
    end
    @(negedge clk);
    rdy_n = 1'b1;
    #1;
    chk(req_ready == 1'b1 && ads_n, "R3 burst ends after count readies", req_ready, 1);
  endtask

  task automatic do_halt(input logic [31:0] exp, input string tag);
    @(negedge clk);
    halt = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_count = 2'd0;
    #1;
    chk(req_ready == 1'b0, "R8 no accept when halt requested", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk(ad_oe && ad_out == exp, tag, ad_out, exp);
    @(posedge clk);
    @(negedge clk);
    chk(ads_n && ad_out == exp, "R8 halt keeps bus parked without access", ad_out, exp);
    halt = 1'b0; req_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_hold_idle;
    @(negedge clk);
    hold = 1'b1; req_valid = 1'b1; req_write = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(hlda && !ad_oe && !ctl_oe && !pa_oe, "R7 float in hold", {hlda, ad_oe, ctl_oe, pa_oe}, 4'b1000);
    chk(!req_ready, "R7 no accept in hold", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk(hlda && ads_n, "R7 hold persists", {hlda, ads_n}, 2'b11);
    hold = 1'b0; req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!hlda && req_ready, "R7 hold release returns to idle", {hlda, req_ready}, 2'b01);
  endtask

  task automatic t_hold_mid_burst;
    @(negedge clk);
    req_write = 1'b0; req_addr = 30'h0123_4560; req_count = 2'd0; req_width = 2'd2;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0; hold = 1'b1;
    @(negedge clk);
    chk(!hlda && ale, "R7 hold deferred in address cycle", {hlda, ale}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    rdy_n = 1'b1;
    #1;
    chk(!hlda && !ad_oe && ctl_oe, "R7 hold deferred in wait cycle", {hlda, ctl_oe}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    rdy_n = 1'b0; ad_in = 32'h0BAD_F00D;
    #1;
    chk(rdat_valid && rdat_data == 32'h0BAD_F00D, "R6 read beat before hold", rdat_data, 32'h0BAD_F00D);
    @(posedge clk);
    @(negedge clk);
    rdy_n = 1'b1;
    #1;
    chk(!hlda && !req_ready, "R7 idle with hold pending blocks accept", {hlda, req_ready}, 2'b00);
    @(posedge clk);
    @(negedge clk);
    chk(hlda && !ad_oe, "R7 hold granted after burst", hlda, 1);
    hold = 1'b0;
    @(posedge clk);
  endtask

  task automatic run_all;
    t_reset();
    // R1 R5: 32-bit write, four beats
    do_burst(1'b1, 30'h2AB_CDE0, 2'b11, 2'd2, 1);
    do_halt({wpat(3)[31:2], 2'b11}, "R8 halt parks last write beat");
    // R4 R6: 32-bit read, offset 3 wraps the partial address
    do_burst(1'b0, 30'h0ABC_DE3, 2'b11, 2'd2, 0);
    do_halt({30'h0ABC_DE3 >> 2, last_pa[3:2], 2'b11}, "R9 halt parks read address and last partial address");
    // R4: 16-bit read, three beats
    do_burst(1'b0, 30'h111_2221, 2'b10, 2'd1, 2);
    // R4: 8-bit write, two beats
    do_burst(1'b1, 30'h333_4442, 2'b01, 2'd0, 1);
    // R4: 8-bit single read
    do_burst(1'b0, 30'h000_0007, 2'b00, 2'd0, 0);
    do_halt({30'h000_0007 >> 2, last_pa[3:2], 2'b00}, "R9 halt after single read");
    t_hold_idle();
    t_hold_mid_burst();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule